// File: doc/BRIEF.md
# Configurable Timer/Counter with Compare Blocking

This block is a timer/counter that can run as an 8-bit or a 16-bit up-counter. It has two compare registers, A and B, a set of three status flags (compare A, compare B, overflow) and one interrupt request per flag. Three mode inputs pick the counter width, whether the compare-A register acts as the counting limit, and whether the capture configuration is selected. The counter moves only on cycles where the timer tick input is high, so an external prescaler or clock-enable source sets its rate.

Software reaches the counter through a byte-wide write path. A write to the high byte is parked in a holding register, and a write to the low byte commits both bytes in one step, so a 16-bit value is never seen half-written. Any write to the counter suppresses compare matches on the tick that falls in the same cycle and on the next tick after it, whether or not the timer is running. This lets a compare register be loaded with the same value as the counter without raising a flag. Compare registers take a new value at once, with no shadow copy.

Flags are cleared either by a write-one-to-clear strobe or by an interrupt acknowledge for that flag. An interrupt request is high while its flag and its enable are both set.

Top module: `cfg_timer`

## Requirements
- R1: After reset the counter is 0x0000, both compare registers are 0, and all three flags and all three interrupt requests are low.
- R2: In the 8-bit normal mode (wide=0, cap=0, ctc=0) the low counter byte advances by one on each tick, goes from 0xFF to 0x00, leaves the high byte unchanged, and holds its value on cycles without a tick; the overflow flag is set by the tick that takes the low byte from 0xFF to 0x00.
- R3: In the 16-bit normal mode (wide=1, cap=0) the full counter advances on each tick and goes from 0xFFFF to 0x0000; the overflow flag is set by that tick and not by the 0x00FF to 0x0100 step.
- R4: In the 8-bit limit mode (wide=0, cap=0, ctc=1) a tick taken while the low byte equals the low byte of compare A returns it to 0x00 without setting the overflow flag; if compare A lies below the count, the byte runs on to 0xFF, returns to 0x00 and sets the overflow flag.
- R5: In every 8-bit mode a tick taken while the low counter byte equals the low byte of compare A (or B) sets flag A (or flag B).
- R6: In the 16-bit modes flag A is set only when all 16 bits of the counter equal compare A, and flag B is never set.
- R7: A write to either counter byte blocks all compare matches on a tick in the same cycle and on the next tick after the write, even when that tick comes many cycles later; the tick after that is evaluated normally.
- R8: A high-byte write alone does not change the counter; a later low-byte write loads {held high byte, written low byte} in one step.
- R9: A compare register write is used by the very next tick.
- R10: Clear strobe mask bit 0 clears flag A, bit 1 flag B, bit 2 overflow; the acknowledge input uses the same bit order; when a flag is set and cleared in the same cycle, the set wins.
- R11: Each interrupt request (A, B, overflow) is high exactly while its flag and its enable bit (same bit order as R10) are both high.
- R12: The capture modes count exactly like the normal mode of the same width, and the ctc input has no effect in them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable; counter moves only when high |
| mode_wide | input | 1 | 1 selects 16-bit counting |
| mode_cap | input | 1 | 1 selects capture configuration |
| mode_ctc | input | 1 | 1 selects compare-A limit (8-bit, non-capture only) |
| cnt_lo_we | input | 1 | Counter low-byte write; commits both bytes |
| cnt_hi_we | input | 1 | Counter high-byte write into holding register |
| cnt_wbyte | input | 8 | Byte written to the counter |
| cmpa_we | input | 1 | Compare A write strobe |
| cmpb_we | input | 1 | Compare B write strobe |
| cmp_wdata | input | 16 | Value written to a compare register |
| flag_clr_we | input | 1 | Write-one-to-clear strobe for flags |
| flag_clr_mask | input | 3 | Flags to clear: bit0 A, bit1 B, bit2 overflow |
| irq_ack | input | 3 | Interrupt acknowledge, same bit order |
| irq_en | input | 3 | Interrupt enables, same bit order |
| count | output | 16 | Current counter value |
| flag_a | output | 1 | Compare A flag |
| flag_b | output | 1 | Compare B flag |
| flag_ovf | output | 1 | Overflow flag |
| irq_a | output | 1 | Compare A interrupt request |
| irq_b | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Counting is driven through both wrap points (0xFF in 8-bit, 0xFFFF in 16-bit), which tells the overflow position of each width apart. Matches are tried with a value equal only in the low byte while in 16-bit mode, and with compare B equal to the count in 16-bit mode, separating the two compare widths. Counter writes are followed both by an immediate tick and by several idle cycles before the tick, and then by an unblocked tick, showing the block spans exactly one tick. The limit mode is run with compare A above and below the count, and the capture mode with the ctc input set, so limit clearing, plain wrapping and ignored ctc are distinguished.

// File: rtl/cfg_timer_pkg.sv
package cfg_timer_pkg;

   typedef enum logic [2:0] {
      TM_NORM8  = 3'd0,
      TM_LIM8   = 3'd1,
      TM_NORM16 = 3'd2,
      TM_CAP8   = 3'd3,
      TM_CAP16  = 3'd4
   } tmr_mode_e;

   localparam int FLG_A   = 0;
   localparam int FLG_B   = 1;
   localparam int FLG_OVF = 2;
   localparam int NUM_FLG = 3;

endpackage

// File: rtl/cfg_timer_mode.sv
module cfg_timer_mode
   import cfg_timer_pkg::*;
(
   input  logic      wide,
   input  logic      cap,
   input  logic      ctc,
   output tmr_mode_e mode,
   output logic      is_wide,
   output logic      is_lim
);

   always_comb begin
      if (cap)       mode = wide ? TM_CAP16 : TM_CAP8;
      else if (wide) mode = TM_NORM16;
      else if (ctc)  mode = TM_LIM8;
      else           mode = TM_NORM8;
   end

   assign is_wide = (mode == TM_NORM16) || (mode == TM_CAP16);
   assign is_lim  = (mode == TM_LIM8);

endmodule

// File: rtl/cfg_timer_counter.sv
module cfg_timer_counter #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              is_wide,
   input  logic              is_lim,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [BYTE_W-1:0] wbyte,
   input  logic [BYTE_W-1:0] limit,
   output logic [CNT_W-1:0]  count,
   output logic              eval_ok,
   output logic              ovf_evt
);

   localparam int HI_W = CNT_W - BYTE_W;

   if (HI_W != BYTE_W) begin : g_bad_width
      $error("cfg_timer_counter: CNT_W must be twice BYTE_W");
   end

   logic [CNT_W-1:0]  cnt_q, cnt_nxt;
   logic [BYTE_W-1:0] hold_q;
   logic              blk_q;
   logic              wr_any;
   logic              at_max;
   logic [BYTE_W-1:0] lo_cur, lo_nxt;

   assign wr_any = lo_we | hi_we;
   assign lo_cur = cnt_q[BYTE_W-1:0];
   assign at_max = is_wide ? (&cnt_q) : (&lo_cur);

   always_comb begin
      lo_nxt = (is_lim && lo_cur == limit) ? '0 : lo_cur + 1'b1;
      if (is_wide) cnt_nxt = cnt_q + 1'b1;
      else         cnt_nxt = {cnt_q[CNT_W-1:BYTE_W], lo_nxt};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hold_q <= '0;
         blk_q  <= 1'b0;
      end else begin
         if (hi_we) hold_q <= wbyte;
         if (lo_we)     cnt_q <= {hold_q, wbyte};
         else if (tick) cnt_q <= cnt_nxt;
         if (wr_any)    blk_q <= 1'b1;
         else if (tick) blk_q <= 1'b0;
      end
   end

   assign count   = cnt_q;
   assign eval_ok = tick & ~blk_q & ~wr_any;
   assign ovf_evt = tick & ~lo_we & at_max;

   // R2: no tick and no commit keeps the count
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !lo_we) |=> $stable(count));

   // R3: at the top of the selected width the count returns to zero
   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !lo_we && is_wide && (&count)) |=> (count == '0));

   // R4: limit reached, low byte returns to zero
   p_lim_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !lo_we && is_lim && count[BYTE_W-1:0] == limit)
      |=> (count[BYTE_W-1:0] == '0));

   // R8: committed value is the held byte over the written byte
   p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we && !hi_we) |=> (count == {$past(hold_q), $past(wbyte)}));

endmodule

// File: rtl/cfg_timer_cmp.sv
module cfg_timer_cmp #(
   parameter int CNT_W   = 16,
   parameter int BYTE_W  = 8,
   parameter bit WIDE_OK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] count,
   input  logic             is_wide,
   input  logic             eval_ok,
   output logic [CNT_W-1:0] ocr,
   output logic             hit
);

   logic [CNT_W-1:0] ocr_q;
   logic             eq_narrow;
   logic             eq_full;

   always_ff @(posedge clk) begin
      if (!rst_n)  ocr_q <= '0;
      else if (we) ocr_q <= wdata;
   end

   assign eq_narrow = (count[BYTE_W-1:0] == ocr_q[BYTE_W-1:0]);

   if (WIDE_OK) begin : g_wide
      assign eq_full = (count == ocr_q);
   end else begin : g_narrow_only
      assign eq_full = 1'b0;
   end

   assign hit = eval_ok & (is_wide ? eq_full : eq_narrow);
   assign ocr = ocr_q;

   // R9: a compare write is visible one cycle later
   p_ocr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ocr == $past(wdata)));

endmodule

// File: rtl/cfg_timer_flags.sv
module cfg_timer_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_we,
   input  logic [N-1:0] clr_mask,
   input  logic [N-1:0] ack,
   input  logic [N-1:0] ien,
   output logic [N-1:0] flags,
   output logic [N-1:0] irq
);

   logic [N-1:0] clr;
   assign clr = (clr_we ? clr_mask : '0) | ack;

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      f_q <= 1'b0;
         else if (set[i]) f_q <= 1'b1;
         else if (clr[i]) f_q <= 1'b0;
      end
      assign flags[i] = f_q;
      assign irq[i]   = f_q & ien[i];

      // R10: a set in the same cycle as a clear leaves the flag high
      p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags[i]);

      // R10: a clear without a set drops the flag
      p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flags[i]);
   end

endmodule

// File: rtl/cfg_timer.sv
module cfg_timer
   import cfg_timer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              mode_wide,
   input  logic              mode_cap,
   input  logic              mode_ctc,
   input  logic              cnt_lo_we,
   input  logic              cnt_hi_we,
   input  logic [BYTE_W-1:0] cnt_wbyte,
   input  logic              cmpa_we,
   input  logic              cmpb_we,
   input  logic [CNT_W-1:0]  cmp_wdata,
   input  logic              flag_clr_we,
   input  logic [2:0]        flag_clr_mask,
   input  logic [2:0]        irq_ack,
   input  logic [2:0]        irq_en,
   output logic [CNT_W-1:0]  count,
   output logic              flag_a,
   output logic              flag_b,
   output logic              flag_ovf,
   output logic              irq_a,
   output logic              irq_b,
   output logic              irq_ovf
);

   tmr_mode_e        mode;
   logic             is_wide, is_lim;
   logic             eval_ok, ovf_evt;
   logic [CNT_W-1:0] ocr_a, ocr_b;
   logic [1:0]       hit;
   logic [NUM_FLG-1:0] set_v, flags_v, irq_v;

   cfg_timer_mode u_mode (
      .wide    (mode_wide),
      .cap     (mode_cap),
      .ctc     (mode_ctc),
      .mode    (mode),
      .is_wide (is_wide),
      .is_lim  (is_lim)
   );

   cfg_timer_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .is_wide (is_wide),
      .is_lim  (is_lim),
      .lo_we   (cnt_lo_we),
      .hi_we   (cnt_hi_we),
      .wbyte   (cnt_wbyte),
      .limit   (ocr_a[BYTE_W-1:0]),
      .count   (count),
      .eval_ok (eval_ok),
      .ovf_evt (ovf_evt)
   );

   for (genvar c = 0; c < 2; c++) begin : g_cmp
      logic             we_c;
      logic [CNT_W-1:0] ocr_c;
      assign we_c = (c == 0) ? cmpa_we : cmpb_we;
      cfg_timer_cmp #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .WIDE_OK(c == 0)) u_cmp (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (we_c),
         .wdata   (cmp_wdata),
         .count   (count),
         .is_wide (is_wide),
         .eval_ok (eval_ok),
         .ocr     (ocr_c),
         .hit     (hit[c])
      );
   end

   assign ocr_a = g_cmp[0].ocr_c;
   assign ocr_b = g_cmp[1].ocr_c;

   always_comb begin
      set_v          = '0;
      set_v[FLG_A]   = hit[0];
      set_v[FLG_B]   = hit[1];
      set_v[FLG_OVF] = ovf_evt;
   end

   cfg_timer_flags #(.N(NUM_FLG)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (set_v),
      .clr_we   (flag_clr_we),
      .clr_mask (flag_clr_mask),
      .ack      (irq_ack),
      .ien      (irq_en),
      .flags    (flags_v),
      .irq      (irq_v)
   );

   assign flag_a   = flags_v[FLG_A];
   assign flag_b   = flags_v[FLG_B];
   assign flag_ovf = flags_v[FLG_OVF];
   assign irq_a    = irq_v[FLG_A];
   assign irq_b    = irq_v[FLG_B];
   assign irq_ovf  = irq_v[FLG_OVF];

   // R6: in 16-bit width flag B stays low
   p_wide_no_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wide && !flag_b && !cmpb_we) |=> !flag_b);

   // R7: a counter write followed by a tick raises no compare flag
   p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_lo_we || cnt_hi_we) && !flag_a && !flag_b) |=> (!flag_a && !flag_b));

   // R11: interrupt requests never appear without their enable
   p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !((irq_a && !irq_en[0]) || (irq_b && !irq_en[1]) || (irq_ovf && !irq_en[2])));

endmodule

// File: tb/cfg_timer_test.sv
module cfg_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        mode_wide = 1'b0, mode_cap = 1'b0, mode_ctc = 1'b0;
   logic        cnt_lo_we = 1'b0, cnt_hi_we = 1'b0;
   logic [7:0]  cnt_wbyte = '0;
   logic        cmpa_we = 1'b0, cmpb_we = 1'b0;
   logic [15:0] cmp_wdata = '0;
   logic        flag_clr_we = 1'b0;
   logic [2:0]  flag_clr_mask = '0, irq_ack = '0, irq_en = '0;
   logic [15:0] count;
   logic        flag_a, flag_b, flag_ovf, irq_a, irq_b, irq_ovf;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      string       req;
      int          sel;
      logic [15:0] exp;
   } item_t;
   item_t sb[$];

   localparam int S_CNT = 0, S_FA = 1, S_FB = 2, S_FO = 3,
                  S_IA = 4, S_IB = 5, S_IO = 6;

   always #2.5 clk = ~clk;

   cfg_timer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .mode_wide(mode_wide), .mode_cap(mode_cap), .mode_ctc(mode_ctc),
      .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we), .cnt_wbyte(cnt_wbyte),
      .cmpa_we(cmpa_we), .cmpb_we(cmpb_we), .cmp_wdata(cmp_wdata),
      .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
      .irq_ack(irq_ack), .irq_en(irq_en),
      .count(count), .flag_a(flag_a), .flag_b(flag_b), .flag_ovf(flag_ovf),
      .irq_a(irq_a), .irq_b(irq_b), .irq_ovf(irq_ovf)
   );

   function automatic logic [15:0] actual(int sel);
      case (sel)
         S_CNT:   return count;
         S_FA:    return {15'd0, flag_a};
         S_FB:    return {15'd0, flag_b};
         S_FO:    return {15'd0, flag_ovf};
         S_IA:    return {15'd0, irq_a};
         S_IB:    return {15'd0, irq_b};
         default: return {15'd0, irq_ovf};
      endcase
   endfunction

   // monitor: compares queued expectations just after each falling edge
   always begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
         item_t it;
         logic [15:0] act;
         it  = sb.pop_front();
         act = actual(it.sel);
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
         end
      end
   end

   task automatic expect_v(input string req, input int sel, input logic [15:0] v);
      item_t it;
      it.req = req; it.sel = sel; it.exp = v;
      sb.push_back(it);
   endtask

   task automatic cyc();
      @(negedge clk);
      tick = 1'b0; cnt_lo_we = 1'b0; cnt_hi_we = 1'b0;
      cmpa_we = 1'b0; cmpb_we = 1'b0; flag_clr_we = 1'b0;
      flag_clr_mask = '0; irq_ack = '0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin tick = 1'b1; cyc(); end
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask
   task automatic wlo(input logic [7:0] b);
      cnt_lo_we = 1'b1; cnt_wbyte = b; cyc();
   endtask
   task automatic whi(input logic [7:0] b);
      cnt_hi_we = 1'b1; cnt_wbyte = b; cyc();
   endtask
   task automatic wa(input logic [15:0] v);
      cmpa_we = 1'b1; cmp_wdata = v; cyc();
   endtask
   task automatic wb(input logic [15:0] v);
      cmpb_we = 1'b1; cmp_wdata = v; cyc();
   endtask
   task automatic clr(input logic [2:0] m);
      flag_clr_we = 1'b1; flag_clr_mask = m; cyc();
   endtask
   task automatic ack(input logic [2:0] m);
      irq_ack = m; cyc();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      expect_v("R1", S_CNT, 16'h0000);
      expect_v("R1", S_FA, 0); expect_v("R1", S_FB, 0); expect_v("R1", S_FO, 0);
      expect_v("R1", S_IA, 0); expect_v("R1", S_IO, 0);

      wa(16'h0010); wb(16'h0020);
      // R2 8-bit counting and wrap
      wlo(8'hFD);
      ticks(2);
      expect_v("R2", S_CNT, 16'h00FF); expect_v("R2", S_FO, 0);
      ticks(1);
      expect_v("R2", S_CNT, 16'h0000); expect_v("R2", S_FO, 1);
      idle(1);
      expect_v("R2", S_CNT, 16'h0000);
      clr(3'b100);
      expect_v("R10", S_FO, 0);

      // R5 8-bit matches
      wlo(8'h0E);
      ticks(3);
      expect_v("R5", S_FA, 1); expect_v("R5", S_FB, 0); expect_v("R5", S_CNT, 16'h0011);
      wb(16'h0011);
      ticks(1);
      expect_v("R9", S_FB, 1); expect_v("R5", S_CNT, 16'h0012);

      // R11 interrupt gating
      irq_en = 3'b011;
      idle(1);
      expect_v("R11", S_IA, 1); expect_v("R11", S_IB, 1); expect_v("R11", S_IO, 0);
      ack(3'b001);
      expect_v("R10", S_FA, 0);
      clr(3'b010);
      expect_v("R10", S_FB, 0); expect_v("R11", S_IB, 0);
      wa(16'h0012);
      tick = 1'b1; flag_clr_we = 1'b1; flag_clr_mask = 3'b001; cyc();
      expect_v("R10", S_FA, 1); expect_v("R10", S_CNT, 16'h0013);
      clr(3'b001);
      irq_en = 3'b000;

      // R7 compare blocking
      wa(16'h0030);
      wlo(8'h30);
      ticks(1);
      expect_v("R7", S_FA, 0); expect_v("R7", S_CNT, 16'h0031);
      wlo(8'h40);
      idle(3);
      wa(16'h0040);
      ticks(1);
      expect_v("R7", S_FA, 0); expect_v("R7", S_CNT, 16'h0041);
      wa(16'h0041);
      ticks(1);
      expect_v("R7", S_FA, 1);
      clr(3'b001);

      // R8 / R6 16-bit writes and matches
      mode_wide = 1'b1;
      whi(8'h12);
      expect_v("R8", S_CNT, 16'h0042);
      wlo(8'h34);
      expect_v("R8", S_CNT, 16'h1234);
      wa(16'h1236); wb(16'h0036);
      ticks(3);
      expect_v("R6", S_FA, 1); expect_v("R6", S_FB, 0); expect_v("R6", S_CNT, 16'h1237);
      clr(3'b001);
      wa(16'h0037);
      ticks(1);
      expect_v("R6", S_FA, 0); expect_v("R6", S_CNT, 16'h1238);

      // R3 16-bit wrap
      whi(8'hFF); wlo(8'hFE);
      ticks(1);
      expect_v("R3", S_CNT, 16'hFFFF); expect_v("R3", S_FO, 0);
      ticks(1);
      expect_v("R3", S_CNT, 16'h0000); expect_v("R3", S_FO, 1);

      // R12 capture 8-bit with ctc set counts as normal
      clr(3'b111);
      mode_wide = 1'b0; mode_cap = 1'b1; mode_ctc = 1'b1;
      whi(8'h00); wlo(8'h01);
      wa(16'h0002);
      ticks(2);
      expect_v("R12", S_CNT, 16'h0003); expect_v("R12", S_FA, 1);

      // R4 limit mode
      clr(3'b111);
      mode_cap = 1'b0;
      wa(16'h0005);
      wlo(8'h03);
      ticks(3);
      expect_v("R4", S_CNT, 16'h0000); expect_v("R4", S_FA, 1); expect_v("R4", S_FO, 0);
      wlo(8'hFE);
      ticks(2);
      expect_v("R4", S_CNT, 16'h0000); expect_v("R4", S_FO, 1);

      idle(2);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule